// File: doc/BRIEF.md
# Timer 2 Interrupt Flag Controller

This block owns the eight-bit control register of the second timer and turns the timer's events into one level interrupt request for the interrupt controller. The counter, the capture and reload datapaths and the baud-rate logic live elsewhere. This block only sees their events: an overflow pulse, a capture/reload strobe, and the synchronized external trigger pin. From these events, and from the mode bits held in the register, it sets two sticky flags. One flag records a counter overflow. The other records an external trigger event. The block drives the request from those two flags.

The CPU reaches the register through a special-function-register port. A byte access uses address C8h. A single-bit access uses addresses C8h to CFh, where the addressed bit is the address minus C8h. Hardware only ever sets the flags and never clears them, not even when the interrupt is taken. Software has to write a flag to zero. Software may also write a flag to one, which forces a request for test.

Top module: `t2_irq_ctrl`

## Requirements
- R1: After reset the register reads 00h and the interrupt request is low.
- R2: An overflow pulse sets the overflow flag (bit 7) only while both baud-clock selects (bit 5 receive, bit 4 transmit) are 0. If either select is 1, the flag is left unchanged.
- R3: The external flag (bit 6) is set when the external-enable bit (bit 3) is 1 and either a falling edge is seen on the pin or the capture/reload strobe is high. A falling edge means a sample of 1 followed by a sample of 0 on the next clock. When bit 3 is 0, neither source affects the flag.
- R4: The request is the OR of the overflow flag and the external flag. The external flag is excluded while the up/down mode input is 1. The request is registered, so it follows the flags one clock later.
- R5: Hardware never clears either flag. A set flag stays set until software writes 0 to it.
- R6: If a hardware set and a software write of 0 hit the same flag in the same cycle, the flag ends up set.
- R7: A software write of 1 to a flag sets it, and the request then rises one clock later.
- R8: A byte write to address C8h loads all eight bits from the write data. A byte write to any other address changes nothing.
- R9: A bit write to address C8h+n (n = 0..7) loads bit n from write-data bit 0 and leaves the other seven bits unchanged.
- R10: A byte read at C8h returns the register. A bit read at C8h+n returns bit n in data bit 0, with the upper bits 0. Any other address reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovf_pulse_i | input | 1 | One-cycle counter overflow event |
| capt_evt_i | input | 1 | Capture/reload strobe caused by the external pin |
| ext_pin_i | input | 1 | Synchronized external trigger pin |
| updown_en_i | input | 1 | Up/down counting mode; removes the external flag from the request |
| sfr_wr_i | input | 1 | Register write strobe |
| sfr_bit_i | input | 1 | 1 = single-bit access, 0 = byte access |
| sfr_addr_i | input | 8 | Register or bit address |
| sfr_wdata_i | input | 8 | Write data; a bit write uses bit 0 |
| sfr_rdata_o | output | 8 | Read data for the current address |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench aims at the cycle where a software clear of a flag collides with a hardware set. A design that gives priority to software would lose that event and leave the flag at 0. It also drives overflows while only one of the two baud-clock selects is set; a design that tests just one of them would set the overflow flag. Bit writes to every address from C8h to CFh, mixed with byte writes to neighbouring addresses, expose a decoder that touches the wrong bit or accepts a stray address. Long idle stretches with flags set, and toggling of the up/down input, catch a design that clears flags by itself, that leaves the external flag in the request during up/down mode, or that changes the request in the same cycle instead of one clock later.

// File: rtl/t2_irq_pkg.sv
package t2_irq_pkg;
  localparam int unsigned CTL_W     = 8;
  localparam int unsigned B_OVF     = 7;
  localparam int unsigned B_EXT     = 6;
  localparam int unsigned B_RXCLK   = 5;
  localparam int unsigned B_TXCLK   = 4;
  localparam int unsigned B_EXTEN   = 3;
  localparam logic [7:0]  CTL_ADDR  = 8'hC8;
  localparam logic [7:0]  BIT_BASE  = 8'hC8;
endpackage

// File: rtl/t2_fall_detect.sv
module t2_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fall_o
);
  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = pin_i;
    fall_o = prev_q & ~pin_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/t2_sfr_decode.sv
module t2_sfr_decode #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned REG_W  = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hC8,
  parameter logic [ADDR_W-1:0] BIT_ADDR = 8'hC8
) (
  input  logic              wr_i,
  input  logic              bit_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [REG_W-1:0]  cur_i,
  output logic [REG_W-1:0]  we_o,
  output logic [REG_W-1:0]  wval_o,
  output logic [REG_W-1:0]  rdata_o
);
  localparam int unsigned IDX_W = $clog2(REG_W);

  logic byte_hit;
  logic bit_hit;
  logic [IDX_W-1:0] idx;

  always_comb begin
    byte_hit = !bit_i && (addr_i == REG_ADDR);
    bit_hit  = bit_i && (addr_i[ADDR_W-1:IDX_W] == BIT_ADDR[ADDR_W-1:IDX_W]);
    idx      = addr_i[IDX_W-1:0];
  end

  for (genvar g = 0; g < REG_W; g++) begin : g_lane
    always_comb begin
      we_o[g]   = wr_i && (byte_hit || (bit_hit && (idx == IDX_W'(g))));
      wval_o[g] = byte_hit ? wdata_i[g] : wdata_i[0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (byte_hit)     rdata_o = cur_i;
    else if (bit_hit) rdata_o[0] = cur_i[idx];
  end
endmodule

// File: rtl/t2_ctl_bit.sv
module t2_ctl_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set_i,
  input  logic sw_we_i,
  input  logic sw_val_i,
  output logic q_o
);
  logic d;

  always_comb begin
    d = q_o;
    if (sw_we_i)  d = sw_val_i;
    if (hw_set_i) d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= d;
  end
endmodule

// File: rtl/t2_irq_ctrl.sv
module t2_irq_ctrl
  import t2_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ovf_pulse_i,
  input  logic       capt_evt_i,
  input  logic       ext_pin_i,
  input  logic       updown_en_i,
  input  logic       sfr_wr_i,
  input  logic       sfr_bit_i,
  input  logic [7:0] sfr_addr_i,
  input  logic [7:0] sfr_wdata_i,
  output logic [7:0] sfr_rdata_o,
  output logic       irq_o
);
  logic [CTL_W-1:0] ctl_q;
  logic [CTL_W-1:0] sw_we;
  logic [CTL_W-1:0] sw_val;
  logic [CTL_W-1:0] hw_set;
  logic             pin_fall;
  logic             irq_d;

  t2_fall_detect u_fall (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (ext_pin_i),
    .fall_o (pin_fall)
  );

  t2_sfr_decode #(
    .ADDR_W   (8),
    .REG_W    (CTL_W),
    .REG_ADDR (CTL_ADDR),
    .BIT_ADDR (BIT_BASE)
  ) u_dec (
    .wr_i    (sfr_wr_i),
    .bit_i   (sfr_bit_i),
    .addr_i  (sfr_addr_i),
    .wdata_i (sfr_wdata_i),
    .cur_i   (ctl_q),
    .we_o    (sw_we),
    .wval_o  (sw_val),
    .rdata_o (sfr_rdata_o)
  );

  // Hardware set sources: only the two flag bits have one.
  always_comb begin
    hw_set        = '0;
    hw_set[B_OVF] = ovf_pulse_i & ~ctl_q[B_RXCLK] & ~ctl_q[B_TXCLK];
    hw_set[B_EXT] = ctl_q[B_EXTEN] & (pin_fall | capt_evt_i);
  end

  for (genvar g = 0; g < CTL_W; g++) begin : g_bit
    t2_ctl_bit u_bit (
      .clk      (clk),
      .rst_n    (rst_n),
      .hw_set_i (hw_set[g]),
      .sw_we_i  (sw_we[g]),
      .sw_val_i (sw_val[g]),
      .q_o      (ctl_q[g])
    );
  end

  always_comb begin
    irq_d = ctl_q[B_OVF] | (ctl_q[B_EXT] & ~updown_en_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= irq_d;
  end
endmodule

// File: rtl/t2_irq_ctrl_chk.sv
module t2_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ovf_pulse_i,
  input logic       capt_evt_i,
  input logic       ext_pin_i,
  input logic       updown_en_i,
  input logic       sfr_wr_i,
  input logic       sfr_bit_i,
  input logic [7:0] sfr_addr_i,
  input logic       irq_o,
  input logic [7:0] ctl_q
);
  logic sw7;
  logic sw6;

  always_comb begin
    sw7 = sfr_wr_i && ((!sfr_bit_i && sfr_addr_i == 8'hC8) || (sfr_bit_i && sfr_addr_i == 8'hCF));
    sw6 = sfr_wr_i && ((!sfr_bit_i && sfr_addr_i == 8'hC8) || (sfr_bit_i && sfr_addr_i == 8'hCE));
  end

  a_r4_irq_lags_flags: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_o == ($past(ctl_q[7]) | ($past(ctl_q[6]) & ~$past(updown_en_i))));

  a_r5_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[7] && !sw7) |=> ctl_q[7]);

  a_r5_ext_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[6] && !sw6) |=> ctl_q[6]);

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_pulse_i && !ctl_q[5] && !ctl_q[4]) |=> ctl_q[7]);

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_pulse_i && (ctl_q[5] || ctl_q[4]) && !ctl_q[7] && !sw7) |=> !ctl_q[7]);

  a_r3_ext_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[3] && !ctl_q[6] && !sw6) |=> !ctl_q[6]);
endmodule

bind t2_irq_ctrl t2_irq_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ovf_pulse_i (ovf_pulse_i),
  .capt_evt_i  (capt_evt_i),
  .ext_pin_i   (ext_pin_i),
  .updown_en_i (updown_en_i),
  .sfr_wr_i    (sfr_wr_i),
  .sfr_bit_i   (sfr_bit_i),
  .sfr_addr_i  (sfr_addr_i),
  .irq_o       (irq_o),
  .ctl_q       (ctl_q)
);

// File: tb/tb_t2_irq_ctrl.sv
module tb_t2_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ovf = 1'b0, capt = 1'b0, pin = 1'b0, updn = 1'b0;
  logic       wr = 1'b0, bitm = 1'b0;
  logic [7:0] addr = 8'hC8, wd = 8'h00;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  logic [7:0] ctl_m = 8'h00;
  logic       prev_m = 1'b0;
  logic       irq_m = 1'b0;

  always #2 clk = ~clk;

  t2_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ovf_pulse_i(ovf), .capt_evt_i(capt),
    .ext_pin_i(pin), .updown_en_i(updn), .sfr_wr_i(wr), .sfr_bit_i(bitm),
    .sfr_addr_i(addr), .sfr_wdata_i(wd), .sfr_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [7:0] model_next(input logic [7:0] c, input logic o, cp, fall,
                                            input logic w, b, input logic [7:0] a, d);
    logic [7:0] n = c;
    if (w && !b && a == 8'hC8) n = d;
    else if (w && b && a[7:3] == 5'h19) n[a[2:0]] = d[0];
    if (o && !c[5] && !c[4]) n[7] = 1'b1;
    if (c[3] && (fall || cp)) n[6] = 1'b1;
    return n;
  endfunction

  task automatic check8(input logic [7:0] act, exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // One cycle: apply stimulus at negedge, update model at posedge, check at next negedge.
  task automatic step(input logic o, cp, p, u, w, b, input logic [7:0] a, d, input string req);
    ovf = o; capt = cp; pin = p; updn = u; wr = w; bitm = b; addr = a; wd = d;
    @(posedge clk);
    irq_m  = ctl_m[7] | (ctl_m[6] & ~u);
    ctl_m  = model_next(ctl_m, o, cp, prev_m & ~p, w, b, a, d);
    prev_m = p;
    @(negedge clk);
    ovf = 0; capt = 0; wr = 0; bitm = 0; addr = 8'hC8;
    #1;
    check8(rdata, ctl_m, req);
    check8({7'b0, irq}, {7'b0, irq_m}, req);
  endtask

  task automatic idle(input string req);
    step(0, 0, pin, updn, 0, 0, 8'hC8, 8'h00, req);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    #5;
    @(negedge clk); #1;
    check8(rdata, 8'h00, "R1");
    check8({7'b0, irq}, 8'h00, "R1");
    rst_n = 1'b1;
    @(negedge clk); #1;
    check8(rdata, 8'h00, "R1");

    // R2: suppressed with either baud select, then allowed
    step(0, 0, 0, 0, 1, 0, 8'hC8, 8'h20, "R8");
    step(1, 0, 0, 0, 0, 0, 8'hC8, 8'h00, "R2");
    step(0, 0, 0, 0, 1, 0, 8'hC8, 8'h10, "R8");
    step(1, 0, 0, 0, 0, 0, 8'hC8, 8'h00, "R2");
    step(0, 0, 0, 0, 1, 0, 8'hC8, 8'h00, "R8");
    step(1, 0, 0, 0, 0, 0, 8'hC8, 8'h00, "R2");
    check8({7'b0, irq}, 8'h00, "R4 lag");
    idle("R4");
    check8({7'b0, irq}, 8'h01, "R4 lag");
    repeat (20) idle("R5");
    check8(rdata, 8'h80, "R5");
    // R6: clear and overflow in the same cycle
    step(1, 0, 0, 0, 1, 1, 8'hCF, 8'h00, "R6");
    check8(rdata, 8'h80, "R6");
    step(0, 0, 0, 0, 1, 1, 8'hCF, 8'h00, "R5");
    check8(rdata, 8'h00, "R5 sw clear");
    // R3: edges with enable off, then on
    step(0, 0, 1, 0, 0, 0, 8'hC8, 8'h00, "R3");
    step(0, 1, 0, 0, 0, 0, 8'hC8, 8'h00, "R3");
    check8(rdata, 8'h00, "R3 disabled");
    step(0, 0, 1, 0, 1, 1, 8'hCB, 8'h01, "R9");
    step(0, 0, 0, 1, 0, 0, 8'hC8, 8'h00, "R3");
    check8(rdata, 8'h48, "R3 fall");
    repeat (3) idle("R4");
    check8({7'b0, irq}, 8'h00, "R4 updown gate");
    step(0, 0, 0, 0, 0, 0, 8'hC8, 8'h00, "R4");
    idle("R4");
    check8({7'b0, irq}, 8'h01, "R4 ext");
    // R7: force overflow flag by software
    step(0, 0, 0, 0, 1, 0, 8'hC8, 8'h00, "R8");
    step(0, 0, 0, 1, 1, 1, 8'hCF, 8'hFF, "R7");
    idle("R7");
    check8({7'b0, irq}, 8'h01, "R7");
    // R8 stray byte address, R9 each bit address
    step(0, 0, 0, 0, 1, 0, 8'hC9, 8'h55, "R8");
    check8(rdata, 8'h80, "R8 stray");
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 1, 1, 8'hC8 + 8'(i), 8'h01, "R9");
    check8(rdata, 8'hFF, "R9");
    // R10 reads
    for (int i = 0; i < 8; i++) begin
      bitm = 1; addr = 8'hC8 + 8'(i); #1;
      check8(rdata, {7'b0, ctl_m[i]}, "R10 bit");
    end
    bitm = 0; addr = 8'h99; #1;
    check8(rdata, 8'h00, "R10 other");
    addr = 8'hC8;

    // Random phase
    for (int n = 0; n < 2000; n++) begin
      logic [7:0] a;
      logic w, b;
      w = ($urandom % 4) == 0;
      b = $urandom % 2;
      case ($urandom % 4)
        0: a = 8'hC8;
        1: a = 8'hC8 + 8'($urandom % 8);
        2: a = 8'hC0 + 8'($urandom % 8);
        default: a = 8'($urandom);
      endcase
      step(($urandom % 3) == 0, ($urandom % 5) == 0, $urandom % 2, ($urandom % 4) == 0,
           w, b, a, 8'($urandom), "R2-R9 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule